// File: doc/BRIEF.md
# Aperture Address Remapping Table

This block remaps device addresses that fall inside one fixed window of the address space onto physical pages. The window starts at a page-aligned base and covers a parameterised number of 4 KiB pages. Each page has one 32-bit table entry. Bit 31 of an entry marks it as valid. Bits 30:12 hold the physical page base. The low 12 bits of a device address pass through to the physical address unchanged.

Software reaches the table through three word registers. One holds the enable bit. One holds an entry selector, and the selector is a full device byte address, not an index. The third is a data window onto the selected entry. A translation port takes a device address and returns either the physical address or a fault, one clock after the request. To restore the table, software programs every entry in ascending order and then sets the enable bit.

Top module: `aperture_remap_top`

## Requirements
- R1: After reset the enable bit reads 0, the selector register reads 0, every entry reads 0, and every translation faults.
- R2: The register offsets are 0x0 for config, 0x4 for the selector and 0x8 for entry data. Read data appears on reg_rdata_o one cycle after the read strobe. Any other offset reads 0, and a write to it changes nothing.
- R3: Bit 0 of config is the enable bit. A config read returns 0 in bits 31:1 and the enable bit in bit 0.
- R4: The selector register stores the whole 32-bit byte address written to it and reads it back unchanged. The entry it selects is (address − base) >> 12.
- R5: A write to entry data stores bit 31 (valid) and bits 30:12 (page base). Reading entry data returns those bits with bits 11:0 as zero.
- R6: While the selector lies outside the window, entry-data writes are dropped and entry-data reads return 0.
- R7: xl_valid_o is high exactly one cycle after xl_req_i. On a hit, xl_pa_o = {0, entry[30:12], addr[11:0]} and xl_fault_o is 0.
- R8: A request made while the enable bit is 0 faults, and on every fault xl_pa_o is 0.
- R9: A request below the base, or at or above base + DEPTH·4 KiB, faults. The last byte of the last page still translates.
- R10: A request whose entry has bit 31 clear faults. Writing an all-zero entry unmaps the page.
- R11: An entry write is visible to a request made in the next cycle. A request made in the same cycle as the write sees the old entry.
- R12: After all entries are written in ascending order, requests fault until the enable bit is set. Once it is set, every page translates to its programmed base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_off_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| xl_req_i | input | 1 | Translation request |
| xl_addr_i | input | 32 | Device address to translate |
| xl_valid_o | output | 1 | Translation result valid |
| xl_pa_o | output | 32 | Physical address, 0 on fault |
| xl_fault_o | output | 1 | Translation fault |

## Verification
Register reads and translation results both come from a single output register. Each is due on the first rising edge after its strobe or request. The bench drives every input on the falling edge and samples on the next falling edge, which is half a cycle after that result edge. Register writes take effect at the same rising edge, so a read or translation issued in any later cycle sees the new value. The same-cycle case is driven on purpose, to show that the old entry is seen (R11).

// File: rtl/aperture_remap_pkg.sv
package aperture_remap_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned PG_W       = WORD_W - PAGE_SHIFT;
  localparam int unsigned PFN_W      = WORD_W - 1 - PAGE_SHIFT;

  localparam logic [3:0] OFF_CFG   = 4'h0;
  localparam logic [3:0] OFF_SEL   = 4'h4;
  localparam logic [3:0] OFF_EDATA = 4'h8;

  typedef struct packed {
    logic             vld;
    logic [PFN_W-1:0] pfn;
  } entry_t;

  function automatic entry_t word_to_entry(logic [WORD_W-1:0] w);
    entry_t e;
    e.vld = w[WORD_W-1];
    e.pfn = w[WORD_W-2:PAGE_SHIFT];
    return e;
  endfunction

  function automatic logic [WORD_W-1:0] entry_to_word(entry_t e);
    return {e.vld, e.pfn, {PAGE_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/aperture_remap_window.sv
module aperture_remap_window
  import aperture_remap_pkg::*;
#(
  parameter logic [WORD_W-1:0] BASE  = 32'h4000_0000,
  parameter int unsigned       DEPTH = 64,
  localparam int unsigned      IDX_W = $clog2(DEPTH)
) (
  input  logic [PG_W-1:0]  pg_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [PG_W-1:0] BASE_PG  = BASE[WORD_W-1:PAGE_SHIFT];
  localparam logic [PG_W-1:0] DEPTH_PG = PG_W'(DEPTH);

  logic [PG_W:0] rel_pg;

  // borrow bit flags addresses below the base
  assign rel_pg = {1'b0, pg_i} - {1'b0, BASE_PG};
  assign hit_o  = !rel_pg[PG_W] && (rel_pg[PG_W-1:0] < DEPTH_PG);
  assign idx_o  = rel_pg[IDX_W-1:0];
endmodule

// File: rtl/aperture_remap_table.sv
module aperture_remap_table
  import aperture_remap_pkg::*;
#(
  parameter int unsigned  DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  entry_t           wentry_i,
  input  logic [IDX_W-1:0] ridx_a_i,
  output entry_t           rentry_a_o,
  input  logic [IDX_W-1:0] ridx_b_i,
  output entry_t           rentry_b_o
);
  localparam logic [IDX_W:0] DEPTH_X = (IDX_W+1)'(DEPTH);

  entry_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))        mem[g] <= wentry_i;
    end
  end

  assign rentry_a_o = ({1'b0, ridx_a_i} < DEPTH_X) ? mem[ridx_a_i] : '0;
  assign rentry_b_o = ({1'b0, ridx_b_i} < DEPTH_X) ? mem[ridx_b_i] : '0;

  // R5: a written entry is readable on the next cycle
  assert_write_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ridx_a_i == widx_i) |=> (($past(ridx_a_i) != ridx_a_i) || rentry_a_o == $past(wentry_i)));
endmodule

// File: rtl/aperture_remap_regs.sv
module aperture_remap_regs
  import aperture_remap_pkg::*;
#(
  parameter logic [WORD_W-1:0] BASE  = 32'h4000_0000,
  parameter int unsigned       DEPTH = 64,
  localparam int unsigned      IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [3:0]        reg_off_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              en_o,
  output logic              tbl_we_o,
  output logic [IDX_W-1:0]  tbl_idx_o,
  output entry_t            tbl_wentry_o,
  input  entry_t            tbl_rentry_i
);
  logic              en_q;
  logic [WORD_W-1:0] sel_q;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              sel_hit;

  aperture_remap_window #(.BASE(BASE), .DEPTH(DEPTH)) u_sel_win (
    .pg_i  (sel_q[WORD_W-1:PAGE_SHIFT]),
    .hit_o (sel_hit),
    .idx_o (tbl_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (reg_we_i) begin
      if (reg_off_i == OFF_CFG) en_q  <= reg_wdata_i[0];
      if (reg_off_i == OFF_SEL) sel_q <= reg_wdata_i;
    end
  end

  assign tbl_we_o     = reg_we_i && (reg_off_i == OFF_EDATA) && sel_hit;
  assign tbl_wentry_o = word_to_entry(reg_wdata_i);

  always_comb begin
    unique case (reg_off_i)
      OFF_CFG:   rdata_d = {{(WORD_W-1){1'b0}}, en_q};
      OFF_SEL:   rdata_d = sel_q;
      OFF_EDATA: rdata_d = sel_hit ? entry_to_word(tbl_rentry_i) : '0;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rdata_d;
  end

  assign reg_rdata_o = rdata_q;
  assign en_o        = en_q;

  assert_cfg_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_off_i == OFF_CFG) |=> en_o == $past(reg_wdata_i[0]));
  assert_cfg_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_off_i == OFF_CFG) |=> reg_rdata_o == {{(WORD_W-1){1'b0}}, $past(en_o)});
  assert_outside_read_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_off_i == OFF_EDATA && !sel_hit) |=> reg_rdata_o == '0);
  assert_low_bits_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_off_i == OFF_EDATA) |=> reg_rdata_o[PAGE_SHIFT-1:0] == '0);
endmodule

// File: rtl/aperture_remap_xlate.sv
module aperture_remap_xlate
  import aperture_remap_pkg::*;
#(
  parameter logic [WORD_W-1:0] BASE  = 32'h4000_0000,
  parameter int unsigned       DEPTH = 64,
  localparam int unsigned      IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              req_i,
  input  logic [WORD_W-1:0] addr_i,
  output logic [IDX_W-1:0]  tbl_idx_o,
  input  entry_t            tbl_rentry_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] pa_o,
  output logic              fault_o
);
  logic              win_hit, hit;
  logic              valid_q, fault_q;
  logic [WORD_W-1:0] pa_q;

  aperture_remap_window #(.BASE(BASE), .DEPTH(DEPTH)) u_req_win (
    .pg_i  (addr_i[WORD_W-1:PAGE_SHIFT]),
    .hit_o (win_hit),
    .idx_o (tbl_idx_o)
  );

  assign hit = en_i && win_hit && tbl_rentry_i.vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      valid_q <= req_i;
      fault_q <= req_i && !hit;
      pa_q    <= (req_i && hit) ? {1'b0, tbl_rentry_i.pfn, addr_i[PAGE_SHIFT-1:0]} : '0;
    end
  end

  assign valid_o = valid_q;
  assign fault_o = fault_q;
  assign pa_o    = pa_q;

  assert_valid_timing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !fault_o && pa_o == '0));
  assert_fault_pa_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> pa_o == '0);
  assert_disabled_faults_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !en_i) |=> fault_o);
  assert_outside_faults_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !win_hit) |=> fault_o);
  assert_invalid_faults_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !tbl_rentry_i.vld) |=> fault_o);
  assert_offset_passes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !fault_o) |-> pa_o[PAGE_SHIFT-1:0] == $past(addr_i[PAGE_SHIFT-1:0]));
endmodule

// File: rtl/aperture_remap_top.sv
module aperture_remap_top
  import aperture_remap_pkg::*;
#(
  parameter logic [31:0] BASE  = 32'h4000_0000,
  parameter int unsigned DEPTH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [3:0]  reg_off_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        xl_req_i,
  input  logic [31:0] xl_addr_i,
  output logic        xl_valid_o,
  output logic [31:0] xl_pa_o,
  output logic        xl_fault_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic             en;
  logic             tbl_we;
  logic [IDX_W-1:0] reg_idx, xl_idx;
  entry_t           tbl_wentry, reg_rentry, xl_rentry;

  aperture_remap_regs #(.BASE(BASE), .DEPTH(DEPTH)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_re_i     (reg_re_i),
    .reg_off_i    (reg_off_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .en_o         (en),
    .tbl_we_o     (tbl_we),
    .tbl_idx_o    (reg_idx),
    .tbl_wentry_o (tbl_wentry),
    .tbl_rentry_i (reg_rentry)
  );

  aperture_remap_table #(.DEPTH(DEPTH)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we),
    .widx_i     (reg_idx),
    .wentry_i   (tbl_wentry),
    .ridx_a_i   (reg_idx),
    .rentry_a_o (reg_rentry),
    .ridx_b_i   (xl_idx),
    .rentry_b_o (xl_rentry)
  );

  aperture_remap_xlate #(.BASE(BASE), .DEPTH(DEPTH)) u_xlate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .req_i        (xl_req_i),
    .addr_i       (xl_addr_i),
    .tbl_idx_o    (xl_idx),
    .tbl_rentry_i (xl_rentry),
    .valid_o      (xl_valid_o),
    .pa_o         (xl_pa_o),
    .fault_o      (xl_fault_o)
  );
endmodule

// File: tb/aperture_remap_top_tb_top.sv
module aperture_remap_top_tb_top;
  localparam logic [31:0] BASE  = 32'h4000_0000;
  localparam int          DEPTH = 64;
  localparam logic [31:0] TOP   = BASE + DEPTH * 4096;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [3:0]  reg_off_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        xl_req_i = 1'b0;
  logic [31:0] xl_addr_i = '0, xl_pa_o;
  logic        xl_valid_o, xl_fault_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  aperture_remap_top #(.BASE(BASE), .DEPTH(DEPTH)) dut_i (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic reg_write(logic [3:0] off, logic [31:0] data);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_off_i = off; reg_wdata_i = data;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_read(logic [3:0] off, output logic [31:0] data);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_off_i = off;
    @(negedge clk_i);
    reg_re_i = 1'b0;
    data = reg_rdata_o;
  endtask

  task automatic xlate(logic [31:0] a, output logic v, output logic f, output logic [31:0] pa);
    @(negedge clk_i);
    xl_req_i = 1'b1; xl_addr_i = a;
    @(negedge clk_i);
    xl_req_i = 1'b0;
    v = xl_valid_o; f = xl_fault_o; pa = xl_pa_o;
  endtask

  function automatic logic [31:0] exp_pa(logic [31:0] e, logic [31:0] a);
    return (e & 32'h7FFF_F000) | (a & 32'h0000_0FFF);
  endfunction

  task automatic expect_hit(string req, logic [31:0] a, logic [31:0] e);
    logic v, f; logic [31:0] pa;
    xlate(a, v, f, pa);
    check({req, " valid"}, {31'b0, v}, 32'd1);
    check({req, " fault"}, {31'b0, f}, 32'd0);
    check({req, " pa"}, pa, exp_pa(e, a));
  endtask

  task automatic expect_fault(string req, logic [31:0] a);
    logic v, f; logic [31:0] pa;
    xlate(a, v, f, pa);
    check({req, " valid"}, {31'b0, v}, 32'd1);
    check({req, " fault"}, {31'b0, f}, 32'd1);
    check({req, " pa zero"}, pa, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    reg_read(4'h0, d); check("R1 cfg", d, 0);
    reg_read(4'h4, d); check("R1 sel", d, 0);
    expect_fault("R1 xlate", BASE + 32'h123);
    reg_write(4'h4, BASE + 7 * 4096);
    reg_read(4'h8, d); check("R1 entry", d, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    reg_write(4'h4, BASE + 32'h3123);
    reg_read(4'h4, d); check("R4 sel readback", d, BASE + 32'h3123);
    reg_read(4'hC, d); check("R2 bad off read", d, 0);
    reg_write(4'hC, 32'hFFFF_FFFF);
    reg_read(4'h0, d); check("R2 bad off write cfg", d, 0);
    reg_read(4'h4, d); check("R2 bad off write sel", d, BASE + 32'h3123);
  endtask

  task automatic t_config;
    logic [31:0] d;
    reg_write(4'h0, 32'hFFFF_FFFF);
    reg_read(4'h0, d); check("R3 cfg set", d, 1);
    reg_write(4'h0, 32'hFFFF_FFFE);
    reg_read(4'h0, d); check("R3 cfg clear", d, 0);
    reg_write(4'h0, 32'h1);
  endtask

  task automatic t_entry;
    logic [31:0] d;
    reg_write(4'h4, BASE + 5 * 4096 + 32'h7FF);
    reg_write(4'h8, 32'h8123_4ABC);
    reg_read(4'h8, d); check("R5 entry readback", d, 32'h8123_4000);
    expect_hit("R7 R4 page5", BASE + 5 * 4096 + 32'h345, 32'h8123_4ABC);
    expect_fault("R4 page4 untouched", BASE + 4 * 4096);
  endtask

  task automatic t_window;
    logic [31:0] d;
    reg_write(4'h4, BASE + 63 * 4096);
    reg_write(4'h8, 32'h8AAA_A000);
    expect_hit("R9 last byte", TOP - 1, 32'h8AAA_A000);
    expect_fault("R9 at top", TOP);
    expect_fault("R9 below base", BASE - 1);
    reg_write(4'h4, TOP);
    reg_write(4'h8, 32'h8555_5000);
    reg_read(4'h8, d); check("R6 outside read", d, 0);
    reg_write(4'h4, BASE - 4096);
    reg_write(4'h8, 32'h8555_5000);
    reg_read(4'h8, d); check("R6 below read", d, 0);
    expect_fault("R6 page0 not written", BASE);
    expect_hit("R6 page63 kept", TOP - 4096, 32'h8AAA_A000);
  endtask

  task automatic t_unmap;
    reg_write(4'h4, BASE + 5 * 4096);
    reg_write(4'h8, 32'h0);
    expect_fault("R10 unmapped", BASE + 5 * 4096 + 32'h10);
    reg_write(4'h4, BASE + 6 * 4096);
    reg_write(4'h8, 32'h7000_0000);
    expect_fault("R10 valid clear", BASE + 6 * 4096);
  endtask

  task automatic t_disable;
    reg_write(4'h0, 32'h0);
    expect_fault("R8 disabled", TOP - 4096);
    reg_write(4'h0, 32'h1);
    expect_hit("R8 reenabled", TOP - 4096, 32'h8AAA_A000);
  endtask

  task automatic t_visibility;
    reg_write(4'h4, BASE + 10 * 4096);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_off_i = 4'h8; reg_wdata_i = 32'h8FFF_F000;
    xl_req_i = 1'b1; xl_addr_i = BASE + 10 * 4096 + 32'h4;
    @(negedge clk_i);
    reg_we_i = 1'b0; xl_req_i = 1'b0;
    check("R11 same cycle fault", {31'b0, xl_fault_o}, 1);
    expect_hit("R11 next cycle", BASE + 10 * 4096 + 32'h4, 32'h8FFF_F000);
  endtask

  task automatic t_restore;
    reg_write(4'h0, 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      reg_write(4'h4, BASE + i * 4096);
      reg_write(4'h8, 32'h8000_0000 | ((i + 32'h100) << 12));
    end
    expect_fault("R12 before enable", BASE + 3 * 4096);
    reg_write(4'h0, 32'h1);
    for (int i = 0; i < DEPTH; i += 9)
      expect_hit("R12 restored", BASE + i * 4096 + i, 32'h8000_0000 | ((i + 32'h100) << 12));
    expect_hit("R12 last", TOP - 2, 32'h8000_0000 | ((DEPTH - 1 + 32'h100) << 12));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_regmap();
    t_config();
    t_entry();
    t_window();
    t_unmap();
    t_disable();
    t_visibility();
    t_restore();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule